// File: doc/BRIEF.md
# Sleep-Mode Wake-Up Controller

This block supervises the low-power halt state of a small microcontroller. When the core executes its halt instruction, the controller parks the core and updates the power-down and time-out status flags. While parked it watches four wake sources: an external reset request, a watchdog overflow, falling edges on an 8-bit port filtered by a per-bit enable mask, and interrupt request lines.

When a wake source fires, the controller waits a start-up delay measured in system clocks. The delay depends on the oscillator kind and, for an external reset, also includes a reset hold time. At the end of the delay it gives the core a one-cycle strobe and a 2-bit code that says how to resume. The core may get a full reset, a watchdog reset, continue at the instruction after the halt, or take the interrupt vector.

The controller does not contain the watchdog counter or the interrupt controller. It only sees their overflow pulse, request flags, enables and the stack-full indication.

States: `ST_RUN` (core executing), `ST_SLEEP` (parked, sources watched), `ST_RST_HOLD` (reset hold after an external-reset wake), `ST_OSC_START` (oscillator start-up count), `ST_RESUME` (one-cycle strobe). The transitions are:

- RUN→SLEEP on a halt command.
- SLEEP→RST_HOLD on an external-reset wake.
- SLEEP→OSC_START on any other wake.
- RST_HOLD→OSC_START when the reset hold count expires.
- OSC_START→RESUME when the start-up count expires.
- RESUME→RUN unconditionally.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After power-up reset, `pdf`, `to_flag`, `halted` and `resume_stb` are all 0.
- R2: A halt command in RUN makes `halted`=1, `pdf`=1 and `to_flag`=0 from the next clock edge on.
- R3: A clear-watchdog command in RUN clears both `pdf` and `to_flag`. If a halt command arrives in the same cycle, the halt wins and `pdf` becomes 1.
- R4: While sleeping, a falling edge on `port_in[n]` wakes the block only if `port_wake_en[n]`=1, and the resume code is 2'b10 (next instruction). An edge on a disabled bit leaves `halted` at 1 and gives no strobe.
- R5: A watchdog overflow while sleeping sets `to_flag` to 1, leaves `pdf` at 1, and gives resume code 2'b01 (watchdog reset).
- R6: An external reset request while sleeping gives resume code 2'b00 (full reset). The wake-to-strobe delay is RST_CYC plus the oscillator start-up count.
- R7: A newly raised interrupt request gives code 2'b11 (vector) if at least one new request line is enabled and the stack is not full. Otherwise it gives 2'b10 (next instruction).
- R8: An interrupt line whose request was already set at the halt command cannot wake the block.
- R9: The start-up count is FAST_START when `osc_rc`=1 and `rc_fast_start`=1, and SLOW_START in every other case.
- R10: When several sources fire in the same cycle, the priority is external reset, then watchdog, then interrupt, then port edge.
- R11: `resume_stb` is high for exactly one cycle, with `halted`=0. It rises N clocks after the edge that captured the wake, where N is the delay total. `resume_act` holds its value until the next wake.
- R12: Port pins pass through a two-flop synchronizer. A pin falling in one cycle is captured as a wake at the third rising edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| halt_cmd | input | 1 | Core executed the halt instruction |
| wdt_clr_cmd | input | 1 | Core executed the clear-watchdog instruction |
| ext_rst_req | input | 1 | External reset request (synchronous) |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| port_in | input | PORT_W | Port pin levels |
| port_wake_en | input | PORT_W | Per-pin falling-edge wake enable |
| irq_req | input | IRQ_N | Interrupt request flags |
| irq_en | input | IRQ_N | Interrupt enables |
| stack_full | input | 1 | Core stack has no free level |
| osc_rc | input | 1 | 1 = RC-type oscillator, 0 = crystal |
| rc_fast_start | input | 1 | RC oscillator uses the short start-up count |
| halted | output | 1 | Core is parked (sleep or start-up delay) |
| pdf | output | 1 | Power-down status flag |
| to_flag | output | 1 | Watchdog time-out status flag |
| resume_stb | output | 1 | One-cycle resume strobe |
| resume_act | output | 2 | 00 full reset, 01 watchdog reset, 10 next instruction, 11 vector |

## Verification
The bench goes after every combination of simultaneous wake sources under all three oscillator settings. It also sweeps interrupt enable and stack-full, so a wrong priority order would show up as a wrong resume code. It counts the strobe delay to the cycle: an off-by-one in the count, a reset hold that is not added, or an ignored fast-start select all move the strobe. Masked port bits and interrupts that were pending before the halt get their own tests, because a design that skips the mask or the snapshot would wake at once. The flag tests include a halt and a clear in the same cycle, and a time-out flag that must survive a wake.

// File: rtl/halt_wake_pkg.sv
package halt_wake_pkg;

    typedef enum logic [1:0] {
        ACT_FULL_RST = 2'b00,
        ACT_WDT_RST  = 2'b01,
        ACT_NEXT     = 2'b10,
        ACT_VECTOR   = 2'b11
    } resume_act_e;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_SLEEP     = 3'd1,
        ST_RST_HOLD  = 3'd2,
        ST_OSC_START = 3'd3,
        ST_RESUME    = 3'd4
    } hw_state_e;

endpackage

// File: rtl/halt_wake_port_edge.sv
module halt_wake_port_edge #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin,
    input  logic [PORT_W-1:0] mask,
    output logic [PORT_W-1:0] fall
);
    logic [PORT_W-1:0] meta_q;
    logic [PORT_W-1:0] sync_q;
    logic [PORT_W-1:0] prev_q;

    for (genvar i = 0; i < PORT_W; i++) begin : g_bit
        // pins idle high: reset to 1 so release of reset is not an edge
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b1;
                sync_q[i] <= 1'b1;
                prev_q[i] <= 1'b1;
            end else begin
                meta_q[i] <= pin[i];
                sync_q[i] <= meta_q[i];
                prev_q[i] <= sync_q[i];
            end
        end
        assign fall[i] = prev_q[i] & ~sync_q[i] & mask[i];
    end

endmodule

// File: rtl/halt_wake_arb.sv
module halt_wake_arb
    import halt_wake_pkg::*;
#(
    parameter int IRQ_N = 2
) (
    input  logic             ext_rst,
    input  logic             wdt_ovf,
    input  logic [IRQ_N-1:0] irq_fresh,
    input  logic [IRQ_N-1:0] irq_en,
    input  logic             stack_full,
    input  logic             port_hit,
    output logic             wake,
    output resume_act_e      act
);
    logic irq_any;
    logic irq_take;

    assign irq_any  = |irq_fresh;
    assign irq_take = (|(irq_fresh & irq_en)) && !stack_full;

    always_comb begin
        wake = 1'b1;
        act  = ACT_NEXT;
        if (ext_rst) begin
            act = ACT_FULL_RST;
        end else if (wdt_ovf) begin
            act = ACT_WDT_RST;
        end else if (irq_any) begin
            act = irq_take ? ACT_VECTOR : ACT_NEXT;
        end else if (port_hit) begin
            act = ACT_NEXT;
        end else begin
            wake = 1'b0;
        end
    end

endmodule

// File: rtl/halt_wake_flags.sv
module halt_wake_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_sleep,
    input  logic wdt_wake,
    input  logic clr_wdt,
    output logic pdf,
    output logic to_flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pdf     <= 1'b0;
            to_flag <= 1'b0;
        end else if (enter_sleep) begin
            pdf     <= 1'b1;
            to_flag <= 1'b0;
        end else if (wdt_wake) begin
            to_flag <= 1'b1;
        end else if (clr_wdt) begin
            pdf     <= 1'b0;
            to_flag <= 1'b0;
        end
    end

    // R2: entering sleep leaves power-down set and time-out clear
    a_r2_entry_flags: assert property (@(posedge clk) disable iff (!rst_n)
        enter_sleep |=> (pdf && !to_flag));

    // R3: a lone clear-watchdog command drops both flags
    a_r3_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wdt && !enter_sleep && !wdt_wake) |=> (!pdf && !to_flag));

    // R5: a watchdog wake keeps the power-down flag
    a_r5_pdf_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_wake && !enter_sleep) |=> (pdf == $past(pdf)));

endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
    import halt_wake_pkg::*;
#(
    parameter int PORT_W     = 8,
    parameter int IRQ_N      = 2,
    parameter int RST_CYC    = 400000,
    parameter int SLOW_START = 1024,
    parameter int FAST_START = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_cmd,
    input  logic              wdt_clr_cmd,
    input  logic              ext_rst_req,
    input  logic              wdt_ovf,
    input  logic [PORT_W-1:0] port_in,
    input  logic [PORT_W-1:0] port_wake_en,
    input  logic [IRQ_N-1:0]  irq_req,
    input  logic [IRQ_N-1:0]  irq_en,
    input  logic              stack_full,
    input  logic              osc_rc,
    input  logic              rc_fast_start,
    output logic              halted,
    output logic              pdf,
    output logic              to_flag,
    output logic              resume_stb,
    output logic [1:0]        resume_act
);
    localparam int MAX_CNT = (RST_CYC > SLOW_START) ? RST_CYC : SLOW_START;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    hw_state_e        state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    resume_act_e      act_q, act_nxt;
    logic [IRQ_N-1:0] irq_snap;
    logic [IRQ_N-1:0] irq_fresh;
    logic [PORT_W-1:0] port_fall;
    logic             arb_wake;
    resume_act_e      arb_act;
    logic             enter_sleep;
    logic             wdt_wake;
    logic             clr_ok;
    logic [CNT_W-1:0] osc_load;
    logic [CNT_W-1:0] rst_load;

    halt_wake_port_edge #(.PORT_W(PORT_W)) u_port (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (port_in),
        .mask  (port_wake_en),
        .fall  (port_fall)
    );

    assign irq_fresh = irq_req & ~irq_snap;

    halt_wake_arb #(.IRQ_N(IRQ_N)) u_arb (
        .ext_rst    (ext_rst_req),
        .wdt_ovf    (wdt_ovf),
        .irq_fresh  (irq_fresh),
        .irq_en     (irq_en),
        .stack_full (stack_full),
        .port_hit   (|port_fall),
        .wake       (arb_wake),
        .act        (arb_act)
    );

    assign enter_sleep = (state == ST_RUN) && halt_cmd;
    assign clr_ok      = (state == ST_RUN) && wdt_clr_cmd;
    assign wdt_wake    = (state == ST_SLEEP) && arb_wake && (arb_act == ACT_WDT_RST);

    halt_wake_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter_sleep (enter_sleep),
        .wdt_wake    (wdt_wake),
        .clr_wdt     (clr_ok),
        .pdf         (pdf),
        .to_flag     (to_flag)
    );

    assign osc_load = (osc_rc && rc_fast_start) ? CNT_W'(FAST_START - 1)
                                                : CNT_W'(SLOW_START - 1);
    assign rst_load = CNT_W'(RST_CYC - 1);

    // next state
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        act_nxt   = act_q;
        unique case (state)
            ST_RUN: begin
                if (halt_cmd) state_nxt = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (arb_wake) begin
                    act_nxt = arb_act;
                    if (arb_act == ACT_FULL_RST) begin
                        state_nxt = ST_RST_HOLD;
                        cnt_nxt   = rst_load;
                    end else begin
                        state_nxt = ST_OSC_START;
                        cnt_nxt   = osc_load;
                    end
                end
            end
            ST_RST_HOLD: begin
                if (cnt == '0) begin
                    state_nxt = ST_OSC_START;
                    cnt_nxt   = osc_load;
                end else begin
                    cnt_nxt = cnt - CNT_W'(1);
                end
            end
            ST_OSC_START: begin
                if (cnt == '0) state_nxt = ST_RESUME;
                else           cnt_nxt   = cnt - CNT_W'(1);
            end
            ST_RESUME: begin
                state_nxt = ST_RUN;
            end
            default: state_nxt = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            cnt      <= '0;
            act_q    <= ACT_FULL_RST;
            irq_snap <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            act_q <= act_nxt;
            if (enter_sleep) irq_snap <= irq_req;
        end
    end

    // outputs
    always_comb begin
        halted     = (state == ST_SLEEP) || (state == ST_RST_HOLD) || (state == ST_OSC_START);
        resume_stb = (state == ST_RESUME);
        resume_act = act_q;
    end

    // R10: external reset outranks every other source
    a_r10_ext_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && ext_rst_req) |=>
            (resume_act == ACT_FULL_RST && state == ST_RST_HOLD));

    // R5: watchdog wake sets time-out and picks the watchdog-reset code
    a_r5_wdt_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && wdt_ovf && !ext_rst_req) |=>
            (to_flag && pdf && resume_act == ACT_WDT_RST));

    // R11: strobe lasts one cycle and the core is released
    a_r11_stb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resume_stb |=> (!resume_stb && !halted));

    // R11: resume code only changes while sleeping
    a_r11_act_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SLEEP) |=> $stable(resume_act));

    // R9: start-up count steps down by one each cycle
    a_r9_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OSC_START && cnt != '0) |=>
            (state == ST_OSC_START && cnt == $past(cnt) - CNT_W'(1)));

    // R8: with no fresh source the block stays asleep
    a_r8_quiet_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !ext_rst_req && !wdt_ovf &&
         (irq_req & ~irq_snap) == '0 && port_fall == '0) |=> (state == ST_SLEEP));

endmodule

// File: tb/halt_wake_ctrl_tb.sv
module halt_wake_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PORT_W = 8;
    localparam int IRQ_N  = 2;
    localparam int RSTC   = 40;
    localparam int SLOW   = 64;
    localparam int FAST   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_cmd = 1'b0, wdt_clr_cmd = 1'b0, ext_rst_req = 1'b0, wdt_ovf = 1'b0;
    logic [PORT_W-1:0] port_in = '1, port_wake_en = '1;
    logic [IRQ_N-1:0] irq_req = '0, irq_en = '0;
    logic stack_full = 1'b0, osc_rc = 1'b0, rc_fast_start = 1'b0;
    logic halted, pdf, to_flag, resume_stb;
    logic [1:0] resume_act;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    halt_wake_ctrl #(
        .PORT_W(PORT_W), .IRQ_N(IRQ_N), .RST_CYC(RSTC),
        .SLOW_START(SLOW), .FAST_START(FAST)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .halt_cmd(halt_cmd), .wdt_clr_cmd(wdt_clr_cmd),
        .ext_rst_req(ext_rst_req), .wdt_ovf(wdt_ovf), .port_in(port_in),
        .port_wake_en(port_wake_en), .irq_req(irq_req), .irq_en(irq_en),
        .stack_full(stack_full), .osc_rc(osc_rc), .rc_fast_start(rc_fast_start),
        .halted(halted), .pdf(pdf), .to_flag(to_flag),
        .resume_stb(resume_stb), .resume_act(resume_act)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int cfg);
        osc_rc        = (cfg != 0);
        rc_fast_start = (cfg != 2);
    endtask

    function automatic int osc_len(input int cfg);
        return (cfg == 1) ? FAST : SLOW;
    endfunction

    task automatic do_halt(input bit with_clr);
        @(negedge clk);
        halt_cmd = 1'b1;
        wdt_clr_cmd = with_clr;
        @(negedge clk);
        halt_cmd = 1'b0;
        wdt_clr_cmd = 1'b0;
        chk(halted == 1'b1, "R2 halted", int'(halted), 1);
        chk(pdf == 1'b1 && to_flag == 1'b0, with_clr ? "R3 halt wins" : "R2 flags",
            int'({pdf, to_flag}), 2);
    endtask

    // counts rising edges from now until strobe is seen at a falling edge
    task automatic wait_stb(output int n);
        n = 0;
        while (n < 5000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            ext_rst_req = 1'b0;
            wdt_ovf     = 1'b0;
            if (resume_stb) break;
        end
    endtask

    task automatic post_stb(input int exp_act, input string req);
        chk(int'(resume_act) == exp_act, req, int'(resume_act), exp_act);
        chk(halted == 1'b0, "R11 released", int'(halted), 0);
        @(negedge clk);
        chk(resume_stb == 1'b0, "R11 one cycle", int'(resume_stb), 0);
        chk(int'(resume_act) == exp_act, "R11 code held", int'(resume_act), exp_act);
    endtask

    task automatic run_case(input int cfg, input bit u_ext, input bit u_wdt, input bit u_irq,
                            input bit u_port, input bit ie, input bit sf, input int b);
        int n, exp_n, exp_act;
        set_cfg(cfg);
        irq_en = {1'b0, ie};
        stack_full = sf;
        port_wake_en = '1;
        do_halt(1'b0);
        if (u_port) begin
            port_in[b] = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
        ext_rst_req = u_ext;
        wdt_ovf     = u_wdt;
        if (u_irq) irq_req[0] = 1'b1;
        wait_stb(n);
        exp_n = (u_ext ? RSTC + osc_len(cfg) : osc_len(cfg)) + 1;
        if (u_ext)      exp_act = 0;
        else if (u_wdt) exp_act = 1;
        else if (u_irq) exp_act = (ie && !sf) ? 3 : 2;
        else            exp_act = 2;
        chk(n == exp_n, u_ext ? "R6 delay" : "R9 delay", n, exp_n);
        chk(to_flag == (u_wdt && !u_ext), "R5 to_flag", int'(to_flag), int'(u_wdt && !u_ext));
        chk(pdf == 1'b1, "R5 pdf kept", int'(pdf), 1);
        post_stb(exp_act, u_ext ? "R6 code" : (u_wdt ? "R10 code" : (u_irq ? "R7 code" : "R4 code")));
        irq_req = '0;
        port_in = '1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int k;
        int n;
        bit stb_seen;
        k = 0;
        repeat (3) @(negedge clk);
        chk(pdf == 0 && to_flag == 0 && halted == 0 && resume_stb == 0, "R1 in reset",
            int'({pdf, to_flag, halted, resume_stb}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(pdf == 0 && to_flag == 0 && halted == 0 && resume_stb == 0, "R1 after reset",
            int'({pdf, to_flag, halted, resume_stb}), 0);

        // sweep every source subset under each oscillator setting (R6 R7 R9 R10)
        for (int cfg = 0; cfg < 3; cfg++) begin
            for (int s = 1; s < 16; s++) begin
                for (int ie = 0; ie < 2; ie++) begin
                    for (int sf = 0; sf < 2; sf++) begin
                        if (!s[2] && (ie != 0 || sf != 0)) continue;
                        run_case(cfg, s[0], s[1], s[2], s[3], ie[0], sf[0], k % PORT_W);
                        k++;
                    end
                end
            end
        end

        // R4 masked pin ignored, then R12 latency through synchronizer
        set_cfg(1);
        port_wake_en = ~(8'h1 << 3);
        do_halt(1'b0);
        port_in[3] = 1'b0;
        stb_seen = 1'b0;
        repeat (12) begin
            @(negedge clk);
            if (resume_stb) stb_seen = 1'b1;
        end
        chk(halted == 1'b1 && !stb_seen, "R4 masked pin", int'(halted), 1);
        port_in[5] = 1'b0;
        wait_stb(n);
        chk(n == FAST + 3, "R12 sync latency", n, FAST + 3);
        post_stb(2, "R4 port code");
        port_in = '1;
        port_wake_en = '1;
        repeat (4) @(negedge clk);

        // R8 request pending at halt does not wake
        irq_en = 2'b11;
        stack_full = 1'b0;
        irq_req[1] = 1'b1;
        repeat (2) @(negedge clk);
        do_halt(1'b0);
        stb_seen = 1'b0;
        repeat (12) begin
            @(negedge clk);
            if (resume_stb) stb_seen = 1'b1;
        end
        chk(halted == 1'b1 && !stb_seen, "R8 pending ignored", int'(halted), 1);
        irq_req[0] = 1'b1;
        wait_stb(n);
        chk(n == FAST + 1, "R8 fresh line delay", n, FAST + 1);
        post_stb(3, "R8 fresh line vector");
        irq_req = '0;
        repeat (2) @(negedge clk);

        // R3 clear command, and halt beating clear in the same cycle
        @(negedge clk);
        wdt_clr_cmd = 1'b1;
        @(negedge clk);
        wdt_clr_cmd = 1'b0;
        chk(pdf == 0 && to_flag == 0, "R3 clear", int'({pdf, to_flag}), 0);
        do_halt(1'b1);
        wdt_ovf = 1'b1;
        wait_stb(n);
        post_stb(1, "R5 wdt code");
        chk(to_flag == 1'b1, "R5 to after wake", int'(to_flag), 1);
        wdt_clr_cmd = 1'b1;
        @(negedge clk);
        wdt_clr_cmd = 1'b0;
        chk(pdf == 0 && to_flag == 0, "R3 clear both", int'({pdf, to_flag}), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule